// File: doc/BRIEF.md
# Power-Down and Wakeup Sequencer

This block decides when a microcontroller subsystem stops its clocks and how it brings them back. The CPU asks for power-down with a write to a control register. The block then drops its oscillator-enable and PLL-enable outputs together and waits. Three sources can end the wait:

- a dedicated wakeup pin;
- a second wakeup pin that can be turned into a plain I/O;
- a bus-activity indication.

On a wakeup the block first turns the oscillator back on and lets it settle for a fixed number of cycles. It then enables the PLL and waits for lock, with a timeout as a fallback. Only after that does it raise a wakeup interrupt. The interrupt status records which sources caused the wakeup. Software clears the status bits by writing ones to them.

The block also stretches reset. A power-on reset is held for a long, parameterised number of cycles. A reset requested while the subsystem is already running is held for a shorter count. While the stretched reset is active, the sequencer is held in its running state with configuration and status cleared. The block runs on an always-on reference clock. Its wakeup inputs pass through two-flop synchronisers.

Top module: `pwr_wake_seq`

## Requirements
- R1: A write with `wr_addr_i`=0 and `wr_data_i[0]`=1, made while running, drives both `osc_en_o` and `pll_en_o` low from the next clock edge. A write to address 0 with bit 0 clear has no effect.
- R2: Wakeup pin A is active low when bit 0 of the configuration register (address 1) is 0, which is the reset value. It is active high when that bit is 1.
- R3: Wakeup pin B follows the polarity in configuration bit 1 (0 means active low). When configuration bit 2 is 1, pin B is a general-purpose I/O and never causes a wakeup.
- R4: `bus_act_i` is active high and wakes the block from power-down, with no configuration needed.
- R5: The wakeup sequence runs in this order:
  - `osc_en_o` rises on the third clock edge after a wakeup input becomes active.
  - `pll_en_o` rises OSC_CYCLES edges after that.
  - `wake_irq_o` rises on the edge where `pll_lock_i` is sampled high. If lock never comes, it rises PLL_TIMEOUT edges after `pll_en_o` rose.
- R6: The status bits are: bit 0 = pin A, bit 1 = pin B, bit 2 = bus activity. Each source that was active in the cycle that started the wakeup has its bit set on the edge where the interrupt rises. `wake_irq_o` is the OR of the status bits.
- R7: A write to address 2 clears every status bit whose data bit is 1 and leaves the other status bits unchanged.
- R8: After `rst_i` is released, `sys_rst_o` stays high and falls on the POR_CYCLES-th edge after the last edge at which `rst_i` was high.
- R9: `sys_rst_o` falls on the WARM_CYCLES-th edge after the last edge at which `rst_req_i` was high. While `sys_rst_o` is high, the sequencer is held running, configuration and status are cleared, and register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| rst_req_i | input | 1 | Reset request while powered |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 power control, 1 configuration, 2 status |
| wr_data_i | input | DATA_W | Register write data |
| wake_pin_a_i | input | 1 | Dedicated wakeup pin (asynchronous) |
| wake_pin_b_i | input | 1 | Second wakeup pin, shared with GPIO (asynchronous) |
| bus_act_i | input | 1 | Bus activity indication (asynchronous) |
| pll_lock_i | input | 1 | PLL lock indication |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| sys_rst_o | output | 1 | Stretched system reset |
| wake_irq_o | output | 1 | Wakeup interrupt |
| wake_cause_o | output | 3 | Wakeup status bits |

## Verification
A wakeup input shows up on `osc_en_o` three edges after it changes: two synchroniser stages and the state register. The bench's reference model carries its own two-stage pipeline and its own countdowns, so the PLL enable is due OSC_CYCLES edges later and the interrupt on the lock edge or at timeout. A register write changes the outputs one edge after the strobe. The stretched reset falls exactly POR_CYCLES or WARM_CYCLES edges after its request. All of these are compared at the falling edge after each rising edge, so every result is judged in the cycle it is due. Directed checks in the scenarios repeat the key outcomes once the sequence has had enough cycles to finish.

// File: rtl/pws_pkg.sv
package pws_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_OSC   = 2'd2,
    ST_PLL   = 2'd3
  } pws_state_e;

  localparam int SRC_N     = 3;
  localparam int SRC_PIN_A = 0;
  localparam int SRC_PIN_B = 1;
  localparam int SRC_BUS   = 2;

  localparam logic [1:0] ADDR_PCON = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic b_gpio;
    logic b_pol;
    logic a_pol;
  } pws_cfg_t;

endpackage

// File: rtl/pws_sync.sv
module pws_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) pipe[0] <= '0;
    else       pipe[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i) pipe[s] <= '0;
      else       pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/pws_rst_stretch.sv
module pws_rst_stretch #(
  parameter int POR_CYCLES  = 240000,
  parameter int WARM_CYCLES = 9600
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic rst_req_i,
  output logic sys_rst_o
);

  localparam int CMAX = (POR_CYCLES > WARM_CYCLES) ? POR_CYCLES : WARM_CYCLES;
  localparam int CW   = $clog2(CMAX + 1);

  logic [CW-1:0] cnt_q;
  logic          hold_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= CW'(POR_CYCLES - 1);
      hold_q <= 1'b1;
    end else if (rst_req_i) begin
      cnt_q  <= CW'(WARM_CYCLES - 1);
      hold_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
      hold_q <= 1'b1;
    end else begin
      hold_q <= 1'b0;
    end
  end

  assign sys_rst_o = hold_q;

  assert_warm_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    rst_req_i |=> sys_rst_o);

  assert_release_after_count_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(sys_rst_o) |-> !$past(rst_req_i));

endmodule

// File: rtl/pws_wake_src.sv
module pws_wake_src
  import pws_pkg::*;
(
  input  logic [SRC_N-1:0] lvl_i,
  input  pws_cfg_t         cfg_i,
  output logic [SRC_N-1:0] hit_o
);

  always_comb begin
    hit_o            = '0;
    hit_o[SRC_PIN_A] = ~(lvl_i[SRC_PIN_A] ^ cfg_i.a_pol);
    hit_o[SRC_PIN_B] = ~(lvl_i[SRC_PIN_B] ^ cfg_i.b_pol) & ~cfg_i.b_gpio;
    hit_o[SRC_BUS]   = lvl_i[SRC_BUS];
  end

endmodule

// File: rtl/pws_fsm.sv
module pws_fsm
  import pws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSC_CYCLES  = 16,
  parameter int PLL_TIMEOUT = 64
) (
  input  logic              clk_i,
  input  logic              srst_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SRC_N-1:0]  hit_i,
  input  logic              pll_lock_i,
  output pws_cfg_t          cfg_o,
  output logic              osc_en_o,
  output logic              pll_en_o,
  output logic              irq_o,
  output logic [SRC_N-1:0]  cause_o
);

  localparam int TMAX = (OSC_CYCLES > PLL_TIMEOUT) ? OSC_CYCLES : PLL_TIMEOUT;
  localparam int TW   = $clog2(TMAX + 1);

  pws_state_e       state_q, state_n;
  logic [TW-1:0]    tmr_q, tmr_n;
  logic [SRC_N-1:0] pend_q, pend_n;
  logic [SRC_N-1:0] stat_q, stat_n;
  pws_cfg_t         cfg_q, cfg_n;

  logic wr_pcon, wr_cfg, wr_stat;
  assign wr_pcon = wr_en_i && (wr_addr_i == ADDR_PCON);
  assign wr_cfg  = wr_en_i && (wr_addr_i == ADDR_CFG);
  assign wr_stat = wr_en_i && (wr_addr_i == ADDR_STAT);

  always_comb begin
    state_n = state_q;
    tmr_n   = tmr_q;
    pend_n  = pend_q;
    stat_n  = stat_q;
    cfg_n   = cfg_q;
    if (wr_cfg)  cfg_n  = pws_cfg_t'(wr_data_i[SRC_N-1:0]);
    if (wr_stat) stat_n = stat_q & ~wr_data_i[SRC_N-1:0];
    unique case (state_q)
      ST_RUN: begin
        if (wr_pcon && wr_data_i[0]) state_n = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (|hit_i) begin
          state_n = ST_OSC;
          tmr_n   = TW'(OSC_CYCLES - 1);
          pend_n  = hit_i;
        end
      end
      ST_OSC: begin
        if (tmr_q == '0) begin
          state_n = ST_PLL;
          tmr_n   = TW'(PLL_TIMEOUT - 1);
        end else begin
          tmr_n = tmr_q - 1'b1;
        end
      end
      ST_PLL: begin
        if (pll_lock_i || tmr_q == '0) begin
          state_n = ST_RUN;
          stat_n  = stat_n | pend_q;
        end else begin
          tmr_n = tmr_q - 1'b1;
        end
      end
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (srst_i) begin
      state_q <= ST_RUN;
      tmr_q   <= '0;
      pend_q  <= '0;
      stat_q  <= '0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_n;
      tmr_q   <= tmr_n;
      pend_q  <= pend_n;
      stat_q  <= stat_n;
      cfg_q   <= cfg_n;
    end
  end

  assign cfg_o    = cfg_q;
  assign osc_en_o = (state_q != ST_SLEEP);
  assign pll_en_o = (state_q == ST_RUN) || (state_q == ST_PLL);
  assign irq_o    = |stat_q;
  assign cause_o  = stat_q;

  assert_sleep_stops_clocks_R1: assert property (@(posedge clk_i) disable iff (srst_i)
    (state_q == ST_RUN && wr_pcon && wr_data_i[0]) |=> (!osc_en_o && !pll_en_o));

  assert_wake_from_sleep_R5: assert property (@(posedge clk_i) disable iff (srst_i)
    $rose(osc_en_o) |-> ($past(state_q) == ST_SLEEP && $past(|hit_i)));

  assert_osc_before_pll_R5: assert property (@(posedge clk_i) disable iff (srst_i)
    $rose(pll_en_o) |-> ($past(osc_en_o) && osc_en_o));

  assert_irq_after_pll_R5: assert property (@(posedge clk_i) disable iff (srst_i)
    $rose(irq_o) |-> ($past(state_q) == ST_PLL));

  assert_gpio_never_wakes_R3: assert property (@(posedge clk_i) disable iff (srst_i)
    (state_q == ST_SLEEP && cfg_q.b_gpio && !hit_i[SRC_PIN_A] && !hit_i[SRC_BUS])
      |=> (state_q == ST_SLEEP));

endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
  import pws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OSC_CYCLES  = 16,
  parameter int PLL_TIMEOUT = 64,
  parameter int POR_CYCLES  = 240000,
  parameter int WARM_CYCLES = 9600
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rst_req_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wake_pin_a_i,
  input  logic              wake_pin_b_i,
  input  logic              bus_act_i,
  input  logic              pll_lock_i,
  output logic              osc_en_o,
  output logic              pll_en_o,
  output logic              sys_rst_o,
  output logic              wake_irq_o,
  output logic [2:0]        wake_cause_o
);

  logic [SRC_N-1:0] raw_lvl, sync_lvl, hit;
  pws_cfg_t         cfg;
  logic             sys_rst;
  logic             fsm_rst;

  assign raw_lvl[SRC_PIN_A] = wake_pin_a_i;
  assign raw_lvl[SRC_PIN_B] = wake_pin_b_i;
  assign raw_lvl[SRC_BUS]   = bus_act_i;

  pws_sync #(.W(SRC_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_lvl),
    .q_o   (sync_lvl)
  );

  pws_rst_stretch #(.POR_CYCLES(POR_CYCLES), .WARM_CYCLES(WARM_CYCLES)) i_rst (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rst_req_i (rst_req_i),
    .sys_rst_o (sys_rst)
  );

  pws_wake_src i_src (
    .lvl_i (sync_lvl),
    .cfg_i (cfg),
    .hit_o (hit)
  );

  assign fsm_rst = rst_i | sys_rst;

  pws_fsm #(
    .DATA_W      (DATA_W),
    .OSC_CYCLES  (OSC_CYCLES),
    .PLL_TIMEOUT (PLL_TIMEOUT)
  ) i_fsm (
    .clk_i      (clk_i),
    .srst_i     (fsm_rst),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .hit_i      (hit),
    .pll_lock_i (pll_lock_i),
    .cfg_o      (cfg),
    .osc_en_o   (osc_en_o),
    .pll_en_o   (pll_en_o),
    .irq_o      (wake_irq_o),
    .cause_o    (wake_cause_o)
  );

  assign sys_rst_o = sys_rst;

endmodule

// File: tb/test_pwr_wake_seq.sv
`timescale 1ns/1ps
module test_pwr_wake_seq;

  localparam int OSC_C  = 5;
  localparam int PLL_T  = 20;
  localparam int POR_C  = 40;
  localparam int WARM_C = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, rst_req = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       pin_a = 1'b1, pin_b = 1'b1, bus = 1'b0, pll_lock = 1'b0;
  logic       osc_en, pll_en, sys_rst, irq;
  logic [2:0] cause;

  pwr_wake_seq #(
    .DATA_W(8), .SYNC_STAGES(2), .OSC_CYCLES(OSC_C), .PLL_TIMEOUT(PLL_T),
    .POR_CYCLES(POR_C), .WARM_CYCLES(WARM_C)
  ) i_pwr_wake_seq (
    .clk_i(clk), .rst_i(rst), .rst_req_i(rst_req), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wake_pin_a_i(pin_a),
    .wake_pin_b_i(pin_b), .bus_act_i(bus), .pll_lock_i(pll_lock),
    .osc_en_o(osc_en), .pll_en_o(pll_en), .sys_rst_o(sys_rst),
    .wake_irq_o(irq), .wake_cause_o(cause)
  );

  int checks = 0, fails = 0;
  bit lock_mode = 1'b1;
  bit done = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: 0 run, 1 sleep, 2 osc settle, 3 pll wait
  int m_state, m_tmr, m_rcnt, m_age;
  bit m_sys, m_valid = 1'b0;
  bit [2:0] m_s1, m_s2, m_cfg, m_pend, m_stat;

  always @(posedge clk) begin
    bit old_sys;
    bit [2:0] h, ncfg, nstat;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_cfg = 0; m_state = 0; m_tmr = 0; m_pend = 0;
      m_stat = 0; m_rcnt = POR_C - 1; m_sys = 1; m_age = 0; m_valid = 1;
    end else begin
      old_sys = m_sys;
      h[0] = (m_s2[0] == m_cfg[0]);
      h[1] = (m_s2[1] == m_cfg[1]) && !m_cfg[2];
      h[2] = m_s2[2];
      m_s2 = m_s1;
      m_s1 = {bus, pin_b, pin_a};
      if (rst_req) begin m_rcnt = WARM_C - 1; m_sys = 1; end
      else if (m_rcnt != 0) begin m_rcnt--; m_sys = 1; end
      else m_sys = 0;
      if (old_sys) begin
        m_state = 0; m_tmr = 0; m_pend = 0; m_stat = 0; m_cfg = 0;
      end else begin
        ncfg = m_cfg; nstat = m_stat;
        if (wr_en && wr_addr == 2'd1) ncfg = wr_data[2:0];
        if (wr_en && wr_addr == 2'd2) nstat = m_stat & ~wr_data[2:0];
        case (m_state)
          0: if (wr_en && wr_addr == 2'd0 && wr_data[0]) m_state = 1;
          1: if (h != 0) begin m_state = 2; m_tmr = OSC_C - 1; m_pend = h; end
          2: if (m_tmr == 0) begin m_state = 3; m_tmr = PLL_T - 1; end else m_tmr--;
          default: if (pll_lock || m_tmr == 0) begin m_state = 0; nstat |= m_pend; end
                   else m_tmr--;
        endcase
        m_cfg = ncfg; m_stat = nstat;
      end
      m_age = (m_state == 3) ? m_age + 1 : 0;
    end
  end

  // Lock driver and per-cycle comparison at the falling edge
  initial forever begin
    @(negedge clk);
    pll_lock = lock_mode && (m_state == 3) && (m_age >= 2);
    if (m_valid) begin
      check("R1 R5", "osc_en", osc_en, m_state != 1);
      check("R1 R5", "pll_en", pll_en, m_state == 0 || m_state == 3);
      check("R8 R9", "sys_rst", sys_rst, m_sys);
      check("R5 R6", "irq", irq, m_stat != 0);
      check("R6 R7", "cause", cause, m_stat);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8", "sys_rst during reset", sys_rst, 1);
    check("R6", "irq after reset", irq, 0);
    rst = 1'b0;
    wait_cyc(POR_C + 3);
    check("R8", "sys_rst released", sys_rst, 0);

    wr(2'd0, 8'h00);
    check("R1", "bit0 clear keeps osc", osc_en, 1);
    wr(2'd0, 8'h01);
    check("R1", "osc off", osc_en, 0);
    check("R1", "pll off", pll_en, 0);

    pin_a = 1'b0;
    wait_cyc(4 + OSC_C + 6);
    check("R2", "default active-low pin A woke", osc_en, 1);
    check("R6", "cause pin A", cause, 3'b001);
    pin_a = 1'b1;
    wr(2'd2, 8'h01);
    check("R7", "w1c cleared", cause, 0);

    wr(2'd1, 8'h06);
    wr(2'd0, 8'h01);
    pin_b = 1'b0; wait_cyc(4); pin_b = 1'b1;
    wait_cyc(20);
    check("R3", "gpio pin B ignored", osc_en, 0);

    lock_mode = 1'b0;
    bus = 1'b1;
    wait_cyc(4 + OSC_C + PLL_T + 4);
    check("R4", "bus woke", osc_en, 1);
    check("R5", "timeout irq", irq, 1);
    check("R4", "cause bus", cause, 3'b100);
    bus = 1'b0; lock_mode = 1'b1;
    wr(2'd2, 8'h02);
    check("R7", "w1c of unset bit keeps", cause, 3'b100);
    wr(2'd2, 8'h04);

    pin_a = 1'b0; pin_b = 1'b0;
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h01);
    wait_cyc(6);
    check("R2", "active-high pin A low stays asleep", osc_en, 0);
    pin_a = 1'b1; pin_b = 1'b1;
    wait_cyc(4 + OSC_C + 8);
    check("R6", "both pins recorded", cause, 3'b011);
    pin_a = 1'b1; pin_b = 1'b1;

    @(negedge clk); rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0;
    check("R9", "warm hold", sys_rst, 1);
    wait_cyc(WARM_C + 2);
    check("R9", "warm released", sys_rst, 0);
    check("R9", "status cleared", cause, 0);

    wait_cyc(5);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule